// File: doc/BRIEF.md
# PLL Reconfiguration Sequencing Controller

This block drives the word-addressed management port of a PLL reconfiguration engine through one complete image reload. A single-cycle request starts a fixed script. The block first writes the image start offset and then writes the start register. It waits for the engine to finish the reload. It then issues paced single-step phase adjustments to two output counters. After a settling time it pulses the PLL reset, which realigns the output counters.

A lock guard runs beside the script. When the PLL's lock indication drops while no reconfiguration is running, the guard issues a reset pulse of the same width. While a reconfiguration is running, any loss of lock is ignored. The PLL, the image memories and the engine sit outside the block. They are seen only through the wait-request, write strobe, address and data signals, and through the lock and reset lines.

Top module: `pllcfg_sequencer`

## Requirements
- R1: `mgmt_wr` is high for single cycles only. A write is present in a cycle only if `mgmt_waitreq` was low at the preceding rising edge.
- R2: The first write of a reconfiguration goes to address 0x1F with data 0x00000000.
- R3: The second write goes to address 0x02 with data 0x00000001. It never occurs without a preceding 0x1F write in the same run.
- R4: After the 0x02 write, no further write is issued until `mgmt_waitreq` has been seen high and then low again.
- R5: The block then issues 15 writes to address 0x06 for counter A, followed by 15 for counter B. The write data is laid out as follows: bits [15:0] = 1 (one step), bits [20:16] = counter select (defaults 1 for A, 2 for B), bit [21] = direction (default 1, up), and all other bits are zero.
- R6: Between two consecutive phase writes there are at least 64 cycles without a write.
- R7: Counting from the cycle of the last phase write W, `pll_rst` is high from cycle W+64+32+1 for exactly 8 cycles. `busy` drops in the cycle after the pulse ends.
- R8: `busy` is high from the cycle after an accepted request until the alignment pulse ends. A request that arrives while `busy` is high has no effect: no extra writes follow.
- R9: While `busy` is low, a high-to-low transition of `pll_locked` makes `pll_rst` high for 8 cycles, starting the cycle after the low level is first sampled. No management write is issued.
- R10: While `busy` is high, a drop of `pll_locked` causes no `pll_rst` pulse.
- R11: A synchronous active-low reset returns the block to idle, with `busy`, `mgmt_wr` and `pll_rst` low in the cycle after the reset edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_req | input | 1 | One-cycle reconfiguration request |
| mgmt_waitreq | input | 1 | Engine wait-request |
| pll_locked | input | 1 | PLL lock indication |
| mgmt_wr | output | 1 | Management write strobe |
| mgmt_addr | output | 6 | Management word address |
| mgmt_wdata | output | 32 | Management write data |
| pll_rst | output | 1 | PLL reset pulse (alignment or lock recovery) |
| busy | output | 1 | Reconfiguration in progress |

## Verification
Every output comes from one register stage. A write appears one cycle after the edge at which wait-request was sampled low, and `busy` appears one cycle after the request. A lock-recovery pulse starts the cycle after the low lock level is first sampled. The alignment pulse starts GAP+SETTLE+1 cycles after the last phase write. The bench numbers each rising edge and samples at the falling edge. It logs every write with its cycle number and compares each logged cycle with the count given in the requirement, not with a waiting window. A small engine model in the bench raises wait-request after each write. It can also hold wait-request high before a request arrives, so the pre-write stall can be observed.

// File: rtl/pllcfg_pkg.sv
// Shared constants, state encoding and data formatting for the PLL
// reconfiguration sequencer. Addresses are word addresses on the engine's
// management port.
package pllcfg_pkg;

    localparam logic [5:0] ADDR_IMG_OFS = 6'h1F;  // image starting offset
    localparam logic [5:0] ADDR_KICK    = 6'h02;  // start image reload
    localparam logic [5:0] ADDR_PHASE   = 6'h06;  // dynamic phase step

    typedef enum logic [3:0] {
        S_IDLE,
        S_OFS_RDY,
        S_OFS_WR,
        S_KICK_RDY,
        S_KICK_WR,
        S_LOAD_BUSY,
        S_LOAD_DONE,
        S_PH_RDY,
        S_PH_WR,
        S_PH_GAP,
        S_SETTLE,
        S_ALIGN
    } seq_state_t;

    // Phase-step word: one step, counter select in [20:16], direction in [21].
    function automatic logic [31:0] phase_word(input logic [4:0] sel, input logic up);
        return {10'd0, up, sel, 16'd1};
    endfunction

endpackage

// File: rtl/pllcfg_seq_fsm.sv
// Script engine: offset write, start write, reload wait, paced phase steps
// for two counters, settling wait, then alignment reset pulse.
// Assumes the engine raises wait-request after the start write and lowers
// it when the reload is complete.
module pllcfg_seq_fsm
    import pllcfg_pkg::*;
#(
    parameter int         NUM_STEPS  = 15,
    parameter int         STEP_GAP   = 64,
    parameter int         SETTLE_CYC = 32,
    parameter int         RST_CYC    = 8,
    parameter logic [4:0] SEL_A      = 5'd1,
    parameter logic [4:0] SEL_B      = 5'd2,
    parameter logic       STEP_UP    = 1'b1
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        req,
    input  logic        waitreq,
    output logic        wr,
    output logic [5:0]  addr,
    output logic [31:0] wdata,
    output logic        align_rst,
    output logic        busy
);

    localparam int MAXC = (STEP_GAP > SETTLE_CYC)
                        ? ((STEP_GAP > RST_CYC) ? STEP_GAP : RST_CYC)
                        : ((SETTLE_CYC > RST_CYC) ? SETTLE_CYC : RST_CYC);
    localparam int TW = $clog2(MAXC + 1);
    localparam int SW = $clog2(NUM_STEPS + 1);

    seq_state_t     state;
    logic [TW-1:0]  tmr;
    logic [SW-1:0]  step_idx;
    logic           on_b;
    logic           last_step;

    assign last_step = on_b && (step_idx == SW'(NUM_STEPS - 1));

    // State, timer and step bookkeeping.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= S_IDLE;
            tmr      <= '0;
            step_idx <= '0;
            on_b     <= 1'b0;
        end else begin
            case (state)
                S_IDLE:      if (req) state <= S_OFS_RDY;
                S_OFS_RDY:   if (!waitreq) state <= S_OFS_WR;
                S_OFS_WR:    state <= S_KICK_RDY;
                S_KICK_RDY:  if (!waitreq) state <= S_KICK_WR;
                S_KICK_WR:   state <= S_LOAD_BUSY;
                S_LOAD_BUSY: if (waitreq) state <= S_LOAD_DONE;
                S_LOAD_DONE: begin
                    if (!waitreq) begin
                        state    <= S_PH_RDY;
                        step_idx <= '0;
                        on_b     <= 1'b0;
                    end
                end
                S_PH_RDY:    if (!waitreq) state <= S_PH_WR;
                S_PH_WR: begin
                    state <= S_PH_GAP;
                    tmr   <= TW'(STEP_GAP - 1);
                end
                S_PH_GAP: begin
                    if (tmr != '0) begin
                        tmr <= tmr - 1'b1;
                    end else if (last_step) begin
                        state <= S_SETTLE;
                        tmr   <= TW'(SETTLE_CYC - 1);
                    end else begin
                        state <= S_PH_RDY;
                        if (step_idx == SW'(NUM_STEPS - 1)) begin
                            step_idx <= '0;
                            on_b     <= 1'b1;
                        end else begin
                            step_idx <= step_idx + 1'b1;
                        end
                    end
                end
                S_SETTLE: begin
                    if (tmr != '0) begin
                        tmr <= tmr - 1'b1;
                    end else begin
                        state <= S_ALIGN;
                        tmr   <= TW'(RST_CYC - 1);
                    end
                end
                S_ALIGN: begin
                    if (tmr != '0) tmr <= tmr - 1'b1;
                    else           state <= S_IDLE;
                end
                default:     state <= S_IDLE;
            endcase
        end
    end

    // Decode the write bus from the registered state.
    always_comb begin
        wr    = 1'b0;
        addr  = '0;
        wdata = '0;
        case (state)
            S_OFS_WR: begin
                wr    = 1'b1;
                addr  = ADDR_IMG_OFS;
                wdata = 32'h0000_0000;
            end
            S_KICK_WR: begin
                wr    = 1'b1;
                addr  = ADDR_KICK;
                wdata = 32'h0000_0001;
            end
            S_PH_WR: begin
                wr    = 1'b1;
                addr  = ADDR_PHASE;
                wdata = phase_word(on_b ? SEL_B : SEL_A, STEP_UP);
            end
            default: ;
        endcase
    end

    assign align_rst = (state == S_ALIGN);
    assign busy      = (state != S_IDLE);

endmodule

// File: rtl/pllcfg_lock_guard.sv
// Loss-of-lock recovery: a falling lock level sampled while not held off
// starts a reset pulse of RST_CYC cycles. Assumes the hold input is high for
// the whole of a reconfiguration.
module pllcfg_lock_guard #(
    parameter int RST_CYC = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic locked,
    input  logic hold,
    output logic lock_rst
);

    localparam int CW = $clog2(RST_CYC + 1);

    logic          locked_q;
    logic [CW-1:0] pulse_cnt;

    // Track previous lock level and run the recovery pulse counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            locked_q  <= 1'b0;
            pulse_cnt <= '0;
        end else begin
            locked_q <= locked;
            if (locked_q && !locked && !hold)
                pulse_cnt <= CW'(RST_CYC);
            else if (pulse_cnt != '0)
                pulse_cnt <= pulse_cnt - 1'b1;
        end
    end

    assign lock_rst = (pulse_cnt != '0);

endmodule

// File: rtl/pllcfg_sequencer.sv
// Top of the PLL reconfiguration sequencer: script engine plus lock guard,
// with both reset sources merged onto one PLL reset line.
module pllcfg_sequencer #(
    parameter int         NUM_STEPS  = 15,
    parameter int         STEP_GAP   = 64,
    parameter int         SETTLE_CYC = 32,
    parameter int         RST_CYC    = 8,
    parameter logic [4:0] SEL_A      = 5'd1,
    parameter logic [4:0] SEL_B      = 5'd2,
    parameter logic       STEP_UP    = 1'b1
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        cfg_req,
    input  logic        mgmt_waitreq,
    input  logic        pll_locked,
    output logic        mgmt_wr,
    output logic [5:0]  mgmt_addr,
    output logic [31:0] mgmt_wdata,
    output logic        pll_rst,
    output logic        busy
);

    logic align_rst;
    logic lock_rst;

    pllcfg_seq_fsm #(
        .NUM_STEPS (NUM_STEPS),
        .STEP_GAP  (STEP_GAP),
        .SETTLE_CYC(SETTLE_CYC),
        .RST_CYC   (RST_CYC),
        .SEL_A     (SEL_A),
        .SEL_B     (SEL_B),
        .STEP_UP   (STEP_UP)
    ) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .req      (cfg_req),
        .waitreq  (mgmt_waitreq),
        .wr       (mgmt_wr),
        .addr     (mgmt_addr),
        .wdata    (mgmt_wdata),
        .align_rst(align_rst),
        .busy     (busy)
    );

    pllcfg_lock_guard #(
        .RST_CYC(RST_CYC)
    ) u_guard (
        .clk     (clk),
        .rst_n   (rst_n),
        .locked  (pll_locked),
        .hold    (busy),
        .lock_rst(lock_rst)
    );

    assign pll_rst = align_rst | lock_rst;

endmodule

// File: rtl/pllcfg_sequencer_chk.sv
// Property checker for pllcfg_sequencer, attached by bind.
module pllcfg_sequencer_chk #(
    parameter int STEP_GAP = 64
) (
    input logic        clk,
    input logic        rst_n,
    input logic        cfg_req,
    input logic        mgmt_waitreq,
    input logic        pll_locked,
    input logic        mgmt_wr,
    input logic [5:0]  mgmt_addr,
    input logic [31:0] mgmt_wdata,
    input logic        pll_rst,
    input logic        busy
);

    logic ofs_seen;
    logic run_q;
    int   gap_cnt;

    // Track offset-before-start order, phase-write spacing and reset history.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ofs_seen <= 1'b0;
            run_q    <= 1'b0;
            gap_cnt  <= STEP_GAP;
        end else begin
            run_q <= 1'b1;
            if (mgmt_wr && mgmt_addr == 6'h1F) ofs_seen <= 1'b1;
            else if (mgmt_wr && mgmt_addr == 6'h02) ofs_seen <= 1'b0;
            if (mgmt_wr && mgmt_addr == 6'h06) gap_cnt <= 0;
            else if (gap_cnt < STEP_GAP) gap_cnt <= gap_cnt + 1;
        end
    end

    a_r1_write_after_ready: assert property (@(posedge clk) disable iff (!rst_n)
        mgmt_wr |-> $past(!mgmt_waitreq));

    a_r1_single_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        mgmt_wr |=> !mgmt_wr);

    a_r2_offset_data: assert property (@(posedge clk) disable iff (!rst_n)
        (mgmt_wr && mgmt_addr == 6'h1F) |-> (mgmt_wdata == 32'h0));

    a_r3_start_after_offset: assert property (@(posedge clk) disable iff (!rst_n)
        (mgmt_wr && mgmt_addr == 6'h02) |-> (ofs_seen && mgmt_wdata == 32'h1));

    a_r5_phase_format: assert property (@(posedge clk) disable iff (!rst_n)
        (mgmt_wr && mgmt_addr == 6'h06) |-> (mgmt_wdata[15:0] == 16'd1 && mgmt_wdata[31:22] == 10'd0));

    a_r6_phase_gap: assert property (@(posedge clk) disable iff (!rst_n)
        (mgmt_wr && mgmt_addr == 6'h06) |-> (gap_cnt >= STEP_GAP));

    a_r7_ends_with_reset: assert property (@(posedge clk) disable iff (!rst_n)
        (run_q && $fell(busy)) |-> $past(pll_rst));

    a_r8_busy_on_req: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_req && !busy) |=> busy);

    a_r8_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !mgmt_wr);

    a_r9_lock_recover: assert property (@(posedge clk) disable iff (!rst_n)
        (run_q && $past(pll_locked) && !pll_locked && !busy) |=> pll_rst);

endmodule

bind pllcfg_sequencer pllcfg_sequencer_chk #(.STEP_GAP(STEP_GAP)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .cfg_req     (cfg_req),
    .mgmt_waitreq(mgmt_waitreq),
    .pll_locked  (pll_locked),
    .mgmt_wr     (mgmt_wr),
    .mgmt_addr   (mgmt_addr),
    .mgmt_wdata  (mgmt_wdata),
    .pll_rst     (pll_rst),
    .busy        (busy)
);

// File: tb/pllcfg_sequencer_test.sv
// Directed bench for pllcfg_sequencer with a simple engine model.
module pllcfg_sequencer_test;

    localparam int GAP    = 64;
    localparam int SETTLE = 32;
    localparam int RSTW   = 8;
    localparam int NSTEP  = 15;
    localparam int LOADW  = 20;
    localparam logic [31:0] WORD_A = 32'h0021_0001;
    localparam logic [31:0] WORD_B = 32'h0022_0001;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req = 1'b0;
    logic        waitreq = 1'b0;
    logic        locked = 1'b1;
    logic        wr;
    logic [5:0]  addr;
    logic [31:0] wdata;
    logic        pll_rst;
    logic        busy;

    always #4 clk = ~clk;

    pllcfg_sequencer uut (
        .clk         (clk),
        .rst_n       (rst_n),
        .cfg_req     (req),
        .mgmt_waitreq(waitreq),
        .pll_locked  (locked),
        .mgmt_wr     (wr),
        .mgmt_addr   (addr),
        .mgmt_wdata  (wdata),
        .pll_rst     (pll_rst),
        .busy        (busy)
    );

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    int checks = 0;
    int errors = 0;
    logic [5:0]  la [0:63];
    logic [31:0] ld [0:63];
    int          lc [0:63];
    int nlog = 0;
    int rst_first = -1;
    int rst_cnt = 0;
    int wr_viol = 0;
    int eng_n = 0;
    int stall_n = 0;
    int fall_cyc = -1;
    bit load_on = 1'b0;

    task automatic summary();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    // Monitor, engine model and watchdog, all at the falling edge.
    always @(negedge clk) begin
        if (rst_n) begin
            if (wr) begin
                if (waitreq) wr_viol++;
                if (nlog < 64) begin
                    la[nlog] = addr;
                    ld[nlog] = wdata;
                    lc[nlog] = cyc;
                end
                nlog++;
            end
            if (pll_rst) begin
                if (rst_first < 0) rst_first = cyc;
                rst_cnt++;
            end
        end
        if (stall_n > 0) begin
            eng_n = stall_n;
            stall_n = 0;
        end
        if (wr && addr == 6'h02) begin
            eng_n = LOADW;
            load_on = 1'b1;
        end else if (wr && addr == 6'h06) begin
            eng_n = 3;
        end
        if (eng_n > 0) begin
            waitreq = 1'b1;
            eng_n--;
        end else begin
            if (load_on && waitreq) begin
                fall_cyc = cyc;
                load_on = 1'b0;
            end
            waitreq = 1'b0;
        end
        if (cyc > 100000) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual %0d expected <100000", cyc);
            summary();
        end
    end

    task automatic check(input bit ok, input string tag, input string what,
                         input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    task automatic clear_log();
        nlog = 0;
        rst_first = -1;
        rst_cnt = 0;
        wr_viol = 0;
        fall_cyc = -1;
    endtask

    task automatic pulse_req();
        @(negedge clk) req = 1'b1;
        @(negedge clk) req = 1'b0;
    endtask

    task automatic wait_idle(output int at);
        at = -1;
        for (int i = 0; i < 5000; i++) begin
            @(negedge clk);
            if (!busy) begin
                at = cyc;
                break;
            end
        end
    endtask

    // R11: outputs idle under reset.
    task automatic t_reset();
        rst_n = 1'b0;
        repeat (4) @(negedge clk);
        check(!busy && !wr && !pll_rst, "R11", "idle in reset", {busy, wr, pll_rst}, 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        check(!busy && !pll_rst, "R11", "idle after release", {busy, pll_rst}, 0);
    endtask

    // Full reconfiguration with stall, lock loss and an ignored request.
    task automatic t_full();
        int end_cyc;
        int mingap;
        bit order_ok;
        int snap;
        clear_log();
        @(negedge clk) stall_n = 8;
        pulse_req();
        check(busy, "R8", "busy after request", busy, 1);
        repeat (4) @(negedge clk);
        check(nlog == 0, "R1", "no write while wait-request high", nlog, 0);
        repeat (150) @(negedge clk);
        locked = 1'b0;
        repeat (4) @(negedge clk);
        locked = 1'b1;
        repeat (100) @(negedge clk);
        pulse_req();
        wait_idle(end_cyc);
        check(nlog == 2 + 2 * NSTEP, "R8", "write count with extra request", nlog, 2 + 2 * NSTEP);
        check(wr_viol == 0, "R1", "writes during wait-request", wr_viol, 0);
        check(la[0] == 6'h1F && ld[0] == 32'h0, "R2", "offset write addr", la[0], 6'h1F);
        check(la[1] == 6'h02 && ld[1] == 32'h1, "R3", "start write addr", la[1], 6'h02);
        check(fall_cyc > 0 && lc[2] > fall_cyc, "R4", "first phase write after reload", lc[2], fall_cyc + 2);
        order_ok = 1'b1;
        for (int i = 2; i < 2 + 2 * NSTEP; i++) begin
            if (la[i] != 6'h06) order_ok = 1'b0;
            if (ld[i] != ((i < 2 + NSTEP) ? WORD_A : WORD_B)) order_ok = 1'b0;
        end
        check(order_ok, "R5", "phase write addresses and words", ld[2], WORD_A);
        check(ld[2 + NSTEP] == WORD_B, "R5", "first counter B word", ld[2 + NSTEP], WORD_B);
        mingap = 100000;
        for (int i = 3; i < 2 + 2 * NSTEP; i++)
            if (lc[i] - lc[i - 1] < mingap) mingap = lc[i] - lc[i - 1];
        check(mingap >= GAP + 1, "R6", "minimum phase write spacing", mingap, GAP + 1);
        check(rst_first == lc[1 + 2 * NSTEP] + GAP + SETTLE + 1, "R7", "alignment reset start",
              rst_first, lc[1 + 2 * NSTEP] + GAP + SETTLE + 1);
        check(rst_cnt == RSTW, "R10", "only alignment pulse despite lock loss", rst_cnt, RSTW);
        check(end_cyc == rst_first + RSTW, "R7", "busy drop cycle", end_cyc, rst_first + RSTW);
        snap = nlog;
        repeat (150) @(negedge clk);
        check(nlog == snap && !busy, "R8", "no rerun from ignored request", nlog, snap);
    endtask

    // R9: lock loss while idle gives one recovery pulse and no writes.
    task automatic t_lock_idle();
        int k;
        clear_log();
        @(negedge clk);
        locked = 1'b0;
        k = cyc;
        repeat (3) @(negedge clk);
        locked = 1'b1;
        repeat (15) @(negedge clk);
        check(rst_first == k + 1, "R9", "recovery pulse start", rst_first, k + 1);
        check(rst_cnt == RSTW, "R9", "recovery pulse width", rst_cnt, RSTW);
        check(nlog == 0 && !busy, "R9", "no writes on lock loss", nlog, 0);
    endtask

    // R11: reset in the middle of a run returns to idle.
    task automatic t_mid_reset();
        int snap;
        clear_log();
        pulse_req();
        repeat (40) @(negedge clk);
        check(busy, "R11", "busy before mid-run reset", busy, 1);
        rst_n = 1'b0;
        @(negedge clk);
        check(!busy && !wr && !pll_rst, "R11", "idle after mid-run reset", {busy, wr, pll_rst}, 0);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        snap = nlog;
        repeat (100) @(negedge clk);
        check(nlog == snap && !busy, "R11", "no writes after reset", nlog, snap);
    endtask

    initial begin
        t_reset();
        t_full();
        t_lock_idle();
        t_mid_reset();
        summary();
    end

endmodule